// File: doc/BRIEF.md
# Disk Sector ID Header Parser

This block sits behind the bit-level decoder and sync detector of a soft-sectored disk read channel. It receives the recovered byte stream one byte per `byte_vld` cycle. A `sync_strobe` flag marks the first byte after the sync prefix. That byte is examined as an address mark. An ID mark starts collection of the header field bytes and then the header check bytes. A data mark is reported with a one-cycle pulse and goes no further, because payload handling belongs elsewhere.

Two header layouts are supported, chosen by `cfg_hdr7`. The 8-byte layout carries cylinder, side, sector and size code as four separate bytes. The 7-byte layout is more compact. It puts the upper cylinder bits into the mark byte itself, and it packs side and size code into a single byte. The header check is either a 16-bit or a 32-bit CRC, chosen by `cfg_crc32`. When a header completes, the block publishes the decoded fields together with a one-cycle pulse. The pulse is `id_valid` when the CRC is good and the decoded sector length equals the configured one. Otherwise it is `id_error`, with `len_mismatch` telling the two causes apart.

Top module: `sector_id_parser`

## Requirements
- R1: While reset is applied and after it, all field outputs are zero and `id_valid`, `id_error`, `len_mismatch` and `dam_seen` are low.
- R2: With `cfg_hdr7`=0, only the byte 0xFE presented with `sync_strobe` opens an ID record. Any other byte value, for example 0xFC, produces no ID pulse and leaves the outputs unchanged. A valid byte without `sync_strobe` while no record is open is ignored.
- R3: With `cfg_hdr7`=1, any strobed byte whose upper six bits are all ones (byte & 0xFC == 0xFC) opens an ID record. The published cylinder is {mark XOR 0xFE, first field byte}, so marks 0xFE, 0xFF, 0xFC and 0xFD give upper bytes 0, 1, 2 and 3.
- R4: An open record collects 4 field bytes in 8-byte mode and 3 in 7-byte mode. In 8-byte mode the fields are, in arrival order, cylinder (the upper output byte is 0), side (the whole byte), sector and size code.
- R5: In 7-byte mode the fields are, in arrival order, cylinder low byte, a side/size byte and the sector number. The side/size byte holds the side in bits 3:0 (output with bits 7:4 zero) and the size code in bits 7:4.
- R6: Size codes 0, 1, 2 and 3 give `sect_len` 128, 256, 512 and 1024. Any larger code gives 0. `cfg_sect_len` uses the same 2-bit code to set the expected length.
- R7: After the fields come 2 CRC bytes (`cfg_crc32`=0) or 4 CRC bytes (`cfg_crc32`=1). The 16-bit CRC uses polynomial 0x1021, and the 32-bit CRC uses 0x04C11DB7. Both start from all ones, shift MSB first, and are cleared at the mark. They cover the mark byte, the field bytes and the CRC bytes, and the header is good when the remainder is zero.
- R8: Exactly one of `id_valid` or `id_error` is high for one cycle, in the cycle after the clock edge that accepts the last CRC byte. The field outputs change only in that cycle and hold otherwise.
- R9: If the decoded length differs from the configured length, the pulse is `id_error` with `len_mismatch` high in the same cycle. `id_valid` requires both a good CRC and a matching length.
- R10: A strobed byte in 0xF8..0xFB raises `dam_seen` for one cycle in the following cycle. It raises no ID pulse and aborts any open record.
- R11: A strobed byte always restarts parsing, discarding any partial record. Idle cycles with `byte_vld` low may appear between bytes without affecting the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hdr7 | input | 1 | 1 = 7-byte header layout, 0 = 8-byte layout |
| cfg_crc32 | input | 1 | 1 = 4 CRC bytes (32-bit), 0 = 2 CRC bytes (16-bit) |
| cfg_sect_len | input | 2 | Expected sector length code (0..3 = 128..1024) |
| byte_vld | input | 1 | Byte present on `byte_in` this cycle |
| sync_strobe | input | 1 | Current byte is the first after the sync prefix |
| byte_in | input | 8 | Recovered data byte |
| id_valid | output | 1 | One-cycle pulse: good header, length matches |
| id_error | output | 1 | One-cycle pulse: CRC failure or length mismatch |
| len_mismatch | output | 1 | High with `id_error` when the length caused it |
| dam_seen | output | 1 | One-cycle pulse: data address mark seen |
| cyl | output | 16 | Cylinder of the last completed header |
| side | output | 8 | Side of the last completed header |
| sector | output | 8 | Sector number of the last completed header |
| sect_len | output | 11 | Decoded sector length in bytes (0 if code unknown) |

## Verification
A corrupted CRC register, or a field counter that is off by one, shows up at the pulse that ends the same record. The pulse either turns into `id_error` or appears a cycle early or late. A wrong field-index mapping leaves the pulse correct but swaps or misplaces cylinder, side or sector values when it fires. A wrong state or a faulty mark decode shows up as a missing pulse, a spurious pulse, or a field change outside a pulse cycle. The field-change case is caught in the same cycle it happens.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int BYTE_W  = 8;
  localparam int CYL_W   = 16;
  localparam int LEN_W   = 11;
  localparam int NFLD_MAX = 4;
  localparam int CNT_W   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIELD = 2'd1,
    ST_CRC   = 2'd2
  } parse_st_e;

  localparam logic [BYTE_W-1:0] IDM_HDR8  = 8'hFE;
  localparam logic [BYTE_W-1:0] IDM_MASK7 = 8'hFC;
  localparam logic [BYTE_W-1:0] CYL_XOR7  = 8'hFE;
  localparam logic [LEN_W-1:0]  LEN_BASE  = 11'd128;
endpackage

// File: rtl/sid_rst_sync.sv
module sid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sid_crc.sv
module sid_crc #(
  parameter int            W    = 16,
  parameter logic [W-1:0]  POLY = 16'h1021,
  parameter logic [W-1:0]  INIT = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       feed,
  input  logic [7:0] din,
  output logic       zero_next
);
  logic [W-1:0] crc_q, crc_d, crc_stepped;

  function automatic logic [W-1:0] crc_step(input logic [W-1:0] c, input logic [7:0] d);
    logic [W-1:0] r;
    logic         fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[W-1] ^ d[i];
      r  = {r[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  always_comb begin
    crc_stepped = crc_step(crc_q, din);
    if (start)     crc_d = crc_step(INIT, din);
    else if (feed) crc_d = crc_stepped;
    else           crc_d = crc_q;
  end

  assign zero_next = (crc_stepped == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              crc_q <= INIT;
    else if (start || feed)  crc_q <= crc_d;
  end
endmodule

// File: rtl/sid_ctrl.sv
module sid_ctrl
  import sid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hdr7,
  input  logic              cfg_crc32,
  input  logic              byte_vld,
  input  logic              sync_strobe,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              crc_start,
  output logic              crc_feed,
  output logic              mark_we,
  output logic              field_we,
  output logic [CNT_W-1:0]  field_idx,
  output logic              done,
  output logic              dam_hit
);
  parse_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_fld, last_crc;
  logic             is_idm, is_dam;

  assign last_fld = cfg_hdr7  ? CNT_W'(2) : CNT_W'(3);
  assign last_crc = cfg_crc32 ? CNT_W'(3) : CNT_W'(1);

  assign is_idm = cfg_hdr7 ? ((byte_in & IDM_MASK7) == IDM_MASK7) : (byte_in == IDM_HDR8);
  assign is_dam = (byte_in[7:2] == 6'b111110);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    crc_start = 1'b0;
    crc_feed  = 1'b0;
    mark_we   = 1'b0;
    field_we  = 1'b0;
    done      = 1'b0;
    dam_hit   = 1'b0;
    if (byte_vld) begin
      if (sync_strobe) begin
        cnt_d = '0;
        if (is_idm) begin
          st_d      = ST_FIELD;
          crc_start = 1'b1;
          mark_we   = 1'b1;
        end else begin
          st_d = ST_IDLE;
          if (is_dam) begin
            dam_hit   = 1'b1;
            crc_start = 1'b1;
          end
        end
      end else begin
        case (st_q)
          ST_FIELD: begin
            field_we = 1'b1;
            crc_feed = 1'b1;
            if (cnt_q == last_fld) begin
              st_d  = ST_CRC;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          ST_CRC: begin
            crc_feed = 1'b1;
            if (cnt_q == last_crc) begin
              done  = 1'b1;
              st_d  = ST_IDLE;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign field_idx = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (byte_vld) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sid_fields.sv
module sid_fields
  import sid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hdr7,
  input  logic [1:0]        cfg_sect_len,
  input  logic              mark_we,
  input  logic              field_we,
  input  logic [CNT_W-1:0]  field_idx,
  input  logic [BYTE_W-1:0] din,
  output logic [CYL_W-1:0]  cyl_dec,
  output logic [7:0]        side_dec,
  output logic [7:0]        sector_dec,
  output logic [LEN_W-1:0]  len_dec,
  output logic              len_bad
);
  logic [BYTE_W-1:0]                 mark_q;
  logic [NFLD_MAX-1:0][BYTE_W-1:0]   fld_q;
  logic [7:0]                        size_code;
  logic [LEN_W-1:0]                  len_want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mark_q <= '0;
    else if (mark_we) mark_q <= din;
  end

  for (genvar g = 0; g < NFLD_MAX; g++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  fld_q[g] <= '0;
      else if (field_we && field_idx == CNT_W'(g)) fld_q[g] <= din;
    end
  end

  always_comb begin
    if (cfg_hdr7) begin
      cyl_dec    = {mark_q ^ CYL_XOR7, fld_q[0]};
      side_dec   = {4'h0, fld_q[1][3:0]};
      sector_dec = fld_q[2];
      size_code  = {4'h0, fld_q[1][7:4]};
    end else begin
      cyl_dec    = {8'h00, fld_q[0]};
      side_dec   = fld_q[1];
      sector_dec = fld_q[2];
      size_code  = fld_q[3];
    end
    len_dec  = (size_code < 8'd4) ? (LEN_BASE << size_code[1:0]) : '0;
    len_want = LEN_BASE << cfg_sect_len;
    len_bad  = (len_dec != len_want);
  end
endmodule

// File: rtl/sector_id_parser.sv
module sector_id_parser
  import sid_pkg::*;
#(
  parameter logic [15:0] CRC16_POLY = 16'h1021,
  parameter logic [15:0] CRC16_INIT = 16'hFFFF,
  parameter logic [31:0] CRC32_POLY = 32'h04C11DB7,
  parameter logic [31:0] CRC32_INIT = 32'hFFFFFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_hdr7,
  input  logic         cfg_crc32,
  input  logic [1:0]   cfg_sect_len,
  input  logic         byte_vld,
  input  logic         sync_strobe,
  input  logic [7:0]   byte_in,
  output logic         id_valid,
  output logic         id_error,
  output logic         len_mismatch,
  output logic         dam_seen,
  output logic [15:0]  cyl,
  output logic [7:0]   side,
  output logic [7:0]   sector,
  output logic [10:0]  sect_len
);
  localparam int NCRC = 2;

  logic             rst_n_i;
  logic             crc_start, crc_feed, mark_we, field_we, done, dam_hit;
  logic [CNT_W-1:0] field_idx;
  logic [NCRC-1:0]  crc_zero;
  logic             crc_ok, len_bad;
  logic [CYL_W-1:0] cyl_dec;
  logic [7:0]       side_dec, sector_dec;
  logic [LEN_W-1:0] len_dec;

  sid_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  sid_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .cfg_hdr7(cfg_hdr7), .cfg_crc32(cfg_crc32),
    .byte_vld(byte_vld), .sync_strobe(sync_strobe), .byte_in(byte_in),
    .crc_start(crc_start), .crc_feed(crc_feed), .mark_we(mark_we),
    .field_we(field_we), .field_idx(field_idx), .done(done), .dam_hit(dam_hit)
  );

  for (genvar g = 0; g < NCRC; g++) begin : g_crc
    localparam int           CW = (g == 0) ? 16 : 32;
    localparam logic [CW-1:0] CP = (g == 0) ? CW'(CRC16_POLY) : CW'(CRC32_POLY);
    localparam logic [CW-1:0] CI = (g == 0) ? CW'(CRC16_INIT) : CW'(CRC32_INIT);
    sid_crc #(.W(CW), .POLY(CP), .INIT(CI)) u_crc (
      .clk(clk), .rst_n(rst_n_i), .start(crc_start), .feed(crc_feed),
      .din(byte_in), .zero_next(crc_zero[g])
    );
  end

  assign crc_ok = cfg_crc32 ? crc_zero[1] : crc_zero[0];

  sid_fields u_fields (
    .clk(clk), .rst_n(rst_n_i), .cfg_hdr7(cfg_hdr7), .cfg_sect_len(cfg_sect_len),
    .mark_we(mark_we), .field_we(field_we), .field_idx(field_idx), .din(byte_in),
    .cyl_dec(cyl_dec), .side_dec(side_dec), .sector_dec(sector_dec),
    .len_dec(len_dec), .len_bad(len_bad)
  );

  logic pass_d;
  assign pass_d = crc_ok && !len_bad;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      id_valid     <= 1'b0;
      id_error     <= 1'b0;
      len_mismatch <= 1'b0;
      dam_seen     <= 1'b0;
    end else begin
      id_valid     <= done && pass_d;
      id_error     <= done && !pass_d;
      len_mismatch <= done && len_bad;
      dam_seen     <= dam_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cyl      <= '0;
      side     <= '0;
      sector   <= '0;
      sect_len <= '0;
    end else if (done) begin
      cyl      <= cyl_dec;
      side     <= side_dec;
      sector   <= sector_dec;
      sect_len <= len_dec;
    end
  end
endmodule

// File: rtl/sid_checker.sv
module sid_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_hdr7,
  input logic [1:0]  cfg_sect_len,
  input logic        byte_vld,
  input logic        sync_strobe,
  input logic [7:0]  byte_in,
  input logic        id_valid,
  input logic        id_error,
  input logic        len_mismatch,
  input logic        dam_seen,
  input logic [15:0] cyl,
  input logic [7:0]  side,
  input logic [7:0]  sector,
  input logic [10:0] sect_len
);
  assert_pulse_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_valid && id_error));

  assert_single_cycle_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid || id_error) |=> !(id_valid || id_error));

  assert_fields_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cyl, side, sector, sect_len}) |-> (id_valid || id_error));

  assert_mismatch_is_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    len_mismatch |-> id_error);

  assert_valid_len_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> (sect_len == (11'd128 << cfg_sect_len)));

  assert_hdr8_cyl_high_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !cfg_hdr7) |-> (cyl[15:8] == 8'h00));

  assert_hdr7_side_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_valid || id_error) && cfg_hdr7) |-> (side[7:4] == 4'h0));

  assert_hdr7_cyl_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_valid || id_error) && cfg_hdr7) |-> (cyl[15:10] == 6'd0));

  assert_dam_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dam_seen |-> $past(byte_vld && sync_strobe && (byte_in[7:2] == 6'b111110)));

  assert_dam_no_id_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dam_seen |-> !(id_valid || id_error));
endmodule

bind sector_id_parser sid_checker u_sid_checker (
  .clk(clk), .rst_n(rst_n), .cfg_hdr7(cfg_hdr7), .cfg_sect_len(cfg_sect_len),
  .byte_vld(byte_vld), .sync_strobe(sync_strobe), .byte_in(byte_in),
  .id_valid(id_valid), .id_error(id_error), .len_mismatch(len_mismatch),
  .dam_seen(dam_seen), .cyl(cyl), .side(side), .sector(sector), .sect_len(sect_len)
);

// File: tb/sector_id_parser_test.sv
`timescale 1ns/1ps
module sector_id_parser_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_hdr7, cfg_crc32;
  logic [1:0]  cfg_sect_len;
  logic        byte_vld, sync_strobe;
  logic [7:0]  byte_in;
  logic        id_valid, id_error, len_mismatch, dam_seen;
  logic [15:0] cyl;
  logic [7:0]  side, sector;
  logic [10:0] sect_len;

  always #2 clk = ~clk;

  sector_id_parser uut (
    .clk(clk), .rst_n(rst_n), .cfg_hdr7(cfg_hdr7), .cfg_crc32(cfg_crc32),
    .cfg_sect_len(cfg_sect_len), .byte_vld(byte_vld), .sync_strobe(sync_strobe),
    .byte_in(byte_in), .id_valid(id_valid), .id_error(id_error),
    .len_mismatch(len_mismatch), .dam_seen(dam_seen), .cyl(cyl), .side(side),
    .sector(sector), .sect_len(sect_len)
  );

  int n_checks = 0, n_errors = 0;
  int n_valid = 0, n_err = 0, n_dam = 0;
  logic last_mm = 1'b0;
  bit finished = 0;

  always @(negedge clk) begin
    if (id_valid) n_valid++;
    if (id_error) begin n_err++; last_mm = len_mismatch; end
    if (dam_seen) n_dam++;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] tb_crc(input logic [31:0] c, input logic [7:0] d, input bit w32);
    logic [31:0] r;
    logic        top;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      top = (w32 ? r[31] : r[15]) ^ d[i];
      r   = r << 1;
      if (top) r = r ^ (w32 ? 32'h04C11DB7 : 32'h00001021);
      if (!w32) r = r & 32'h0000FFFF;
    end
    return r;
  endfunction

  logic [7:0] fr [0:11];
  int         nfr;

  task automatic make_frame(input bit h7, input bit c32, input logic [7:0] mk,
                            input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3, input bit bad);
    logic [31:0] c;
    int nf;
    nf = h7 ? 3 : 4;
    fr[0] = mk; fr[1] = b0; fr[2] = b1; fr[3] = b2; fr[4] = b3;
    c = c32 ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int i = 0; i <= nf; i++) c = tb_crc(c, fr[i], c32);
    if (c32) begin
      fr[nf+1] = c[31:24]; fr[nf+2] = c[23:16]; fr[nf+3] = c[15:8]; fr[nf+4] = c[7:0];
      nfr = nf + 5;
    end else begin
      fr[nf+1] = c[15:8]; fr[nf+2] = c[7:0];
      nfr = nf + 3;
    end
    if (bad) fr[nfr-1] = fr[nfr-1] ^ 8'h01;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit strobe, input bit gap);
    @(negedge clk);
    byte_vld = 1'b1; sync_strobe = strobe; byte_in = b;
    if (gap) begin
      @(negedge clk);
      byte_vld = 1'b0; sync_strobe = 1'b0; byte_in = 8'h5A;
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    byte_vld = 1'b0; sync_strobe = 1'b0; byte_in = 8'h00;
  endtask

  task automatic send_frame(input bit strobe_first, input bit gaps);
    for (int i = 0; i < nfr; i++) send_byte(fr[i], strobe_first && (i == 0), gaps);
    idle_cycle();
    idle_cycle();
  endtask

  typedef struct packed {
    logic        h7; logic c32; logic [1:0] len; logic bad;
    logic [7:0]  mk, b0, b1, b2, b3;
    logic        ev; logic emm;
    logic [15:0] cyl; logic [7:0] side, sec; logic [10:0] slen;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [0:NV-1] = '{
    '{1'b0,1'b0,2'd2,1'b0,8'hFE,8'h05,8'h01,8'h09,8'h02,1'b1,1'b0,16'h0005,8'h01,8'h09,11'd512},
    '{1'b0,1'b1,2'd1,1'b0,8'hFE,8'h4C,8'h00,8'h01,8'h01,1'b1,1'b0,16'h004C,8'h00,8'h01,11'd256},
    '{1'b1,1'b0,2'd2,1'b0,8'hFF,8'h34,8'h23,8'h11,8'h00,1'b1,1'b0,16'h0134,8'h03,8'h11,11'd512},
    '{1'b1,1'b1,2'd3,1'b0,8'hFC,8'h02,8'h30,8'h07,8'h00,1'b1,1'b0,16'h0202,8'h00,8'h07,11'd1024},
    '{1'b1,1'b0,2'd0,1'b0,8'hFD,8'h80,8'h41,8'h05,8'h00,1'b0,1'b1,16'h0380,8'h01,8'h05,11'd0},
    '{1'b0,1'b0,2'd2,1'b1,8'hFE,8'h01,8'h00,8'h02,8'h02,1'b0,1'b0,16'h0001,8'h00,8'h02,11'd512},
    '{1'b1,1'b0,2'd1,1'b0,8'hFE,8'h4F,8'h12,8'h03,8'h00,1'b1,1'b0,16'h004F,8'h02,8'h03,11'd256},
    '{1'b0,1'b1,2'd2,1'b0,8'hFE,8'h0A,8'h01,8'h03,8'h03,1'b0,1'b1,16'h000A,8'h01,8'h03,11'd1024}
  };

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int v0, e0, d0;
    rst_n = 1'b0; cfg_hdr7 = 1'b0; cfg_crc32 = 1'b0; cfg_sect_len = 2'd2;
    byte_vld = 1'b0; sync_strobe = 1'b0; byte_in = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cyl", 32'(cyl), 0);
    check("R1 side", 32'(side), 0);
    check("R1 sector", 32'(sector), 0);
    check("R1 sect_len", 32'(sect_len), 0);
    check("R1 pulses", {28'd0, id_valid, id_error, len_mismatch, dam_seen}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 pulses after release", {28'd0, id_valid, id_error, len_mismatch, dam_seen}, 0);

    // Vector table: R3 R4 R5 R6 R7 R9 R11
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VT[k];
      @(negedge clk);
      cfg_hdr7 = v.h7; cfg_crc32 = v.c32; cfg_sect_len = v.len;
      v0 = n_valid; e0 = n_err; last_mm = 1'b0;
      make_frame(v.h7, v.c32, v.mk, v.b0, v.b1, v.b2, v.b3, v.bad);
      send_frame(1'b1, (k % 2) == 1);
      check($sformatf("R7 R9 vec%0d valid pulses", k), 32'(n_valid - v0), {31'd0, v.ev});
      check($sformatf("R7 R9 vec%0d error pulses", k), 32'(n_err - e0), {31'd0, !v.ev});
      check($sformatf("R9 vec%0d len_mismatch", k), {31'd0, last_mm}, {31'd0, v.emm});
      check($sformatf("R3 R4 vec%0d cyl", k), 32'(cyl), 32'(v.cyl));
      check($sformatf("R4 R5 vec%0d side", k), 32'(side), 32'(v.side));
      check($sformatf("R4 R5 vec%0d sector", k), 32'(sector), 32'(v.sec));
      check($sformatf("R6 vec%0d sect_len", k), 32'(sect_len), 32'(v.slen));
    end

    // R8: pulse timing, exactly one cycle after the last CRC byte edge
    cfg_hdr7 = 1'b0; cfg_crc32 = 1'b0; cfg_sect_len = 2'd1;
    make_frame(1'b0, 1'b0, 8'hFE, 8'h21, 8'h01, 8'h0E, 8'h01, 1'b0);
    for (int i = 0; i < nfr; i++) begin
      send_byte(fr[i], i == 0, 1'b0);
      if (i < nfr - 1) check("R8 no early pulse", {31'd0, id_valid | id_error}, 0);
    end
    idle_cycle();
    check("R8 pulse in cycle after last byte", {31'd0, id_valid}, 1);
    check("R8 cyl with pulse", 32'(cyl), 32'h21);
    idle_cycle();
    check("R8 pulse lasts one cycle", {31'd0, id_valid}, 0);
    check("R8 fields held", 32'(sector), 32'h0E);

    // R2: 8-byte mode rejects 0xFC mark
    v0 = n_valid; e0 = n_err;
    make_frame(1'b0, 1'b0, 8'hFC, 8'h33, 8'h00, 8'h44, 8'h01, 1'b0);
    send_frame(1'b1, 1'b0);
    check("R2 FC mark ignored in 8-byte mode", 32'((n_valid - v0) + (n_err - e0)), 0);
    check("R2 cyl unchanged", 32'(cyl), 32'h21);

    // R2: unstrobed bytes while idle are ignored
    make_frame(1'b0, 1'b0, 8'hFE, 8'h66, 8'h00, 8'h44, 8'h01, 1'b0);
    send_frame(1'b0, 1'b0);
    check("R2 unstrobed frame ignored", 32'((n_valid - v0) + (n_err - e0)), 0);
    check("R2 sector unchanged", 32'(sector), 32'h0E);

    // R10: data address marks
    d0 = n_dam;
    send_byte(8'hF9, 1'b1, 1'b0);
    idle_cycle();
    check("R10 dam_seen after F9", {31'd0, dam_seen}, 1);
    idle_cycle();
    check("R10 dam_seen one cycle", {31'd0, dam_seen}, 0);
    send_byte(8'hF8, 1'b1, 1'b1);
    send_byte(8'hFB, 1'b1, 1'b1);
    send_byte(8'hF7, 1'b1, 1'b1);
    idle_cycle();
    check("R10 dam count F9 F8 FB", 32'(n_dam - d0), 3);
    // R10: a data mark aborts an open ID record
    make_frame(1'b0, 1'b0, 8'hFE, 8'h77, 8'h00, 8'h01, 8'h01, 1'b0);
    send_byte(fr[0], 1'b1, 1'b0);
    send_byte(fr[1], 1'b0, 1'b0);
    send_byte(8'hFA, 1'b1, 1'b0);
    for (int i = 2; i < nfr; i++) send_byte(fr[i], 1'b0, 1'b0);
    idle_cycle(); idle_cycle();
    check("R10 aborted record gives no ID pulse", 32'((n_valid - v0) + (n_err - e0)), 0);
    check("R10 cyl unchanged by aborted record", 32'(cyl), 32'h21);

    // R11: strobed mark mid-record restarts parsing
    cfg_hdr7 = 1'b1; cfg_sect_len = 2'd2;
    make_frame(1'b1, 1'b0, 8'hFF, 8'h10, 8'h21, 8'h02, 8'h00, 1'b0);
    send_byte(fr[0], 1'b1, 1'b0);
    send_byte(fr[1], 1'b0, 1'b0);
    send_byte(fr[2], 1'b0, 1'b0);
    make_frame(1'b1, 1'b0, 8'hFD, 8'h99, 8'h24, 8'h08, 8'h00, 1'b0);
    send_frame(1'b1, 1'b1);
    check("R11 single pulse after restart", 32'(n_valid - v0), 1);
    check("R11 cyl from second record", 32'(cyl), 32'h0399);
    check("R11 side from second record", 32'(side), 32'h04);
    check("R11 error count", 32'(n_err - e0), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule